// File: doc/BRIEF.md
# Interleaved Pixel Link Demultiplexer

This block sits between a display receiver's parallel pixel bus and the parallel inputs of a panel-side serializer. It forms two output channels, A and B. In the direct modes every input cycle carries one pixel time. In the interleaved mode one input link carries deep-colour pixels as pairs of beats at twice the pixel rate, and the block rebuilds each pixel from its two beats. The block runs on one clock at the input beat rate. A pixel-rate enable, `out_en`, marks each output pixel time. In the direct modes `out_en` is high on every cycle. In the interleaved mode it pulses on every second cycle, so a downstream divider or clock-enabled serializer can run at the pixel rate.

Four link modes are decoded from `mode_sel`: 0 = 12-bit dual link, 1 = 12-bit interleaved single link, 2 = 8-bit dual link, 3 = 8-bit single link. The mode is taken only during blanking. The display-enable and both sync signals are delayed together with the pixel words so that they stay aligned. A line that ends partway through a beat pair is discarded and flagged.

Top module: `pixel_link_demux`

## Requirements
- R1: While `rst_n` is low, every output is zero, including `out_en` and `odd_err`.
- R2: `mode_sel` is latched only on cycles where `in_de` is low. A change of `mode_sel` during an active line has no effect on how that line is converted.
- R3: Mode 0 (12-bit dual link): one cycle after each input cycle, `out_en` is high, `out_a` equals `in_a`, and `out_b` equals `in_b[3:0]` with bits [7:4] set to zero.
- R4: Mode 1 (interleaved): a pixel is two consecutive beats on `in_a`. The first beat carries bits [11:4] and the second carries bits [3:0] in `in_a[3:0]`. One cycle after the second beat, `out_en` is high, `out_a` holds the first beat and `out_b` holds the second beat's low nibble with bits [7:4] zero. `out_en` is never high on two consecutive cycles within a line.
- R5: In mode 1, the first active beat of every line (the cycle where `in_de` rises) is always treated as the bits [11:4] beat, whatever the beat phase was during blanking.
- R6: Mode 2 (8-bit dual link): `in_a` (even pixel) and `in_b` (odd pixel) pass unchanged to `out_a` and `out_b` one cycle later.
- R7: Mode 3 (8-bit single link): `in_a` passes to `out_a` one cycle later, and `out_b` is zero.
- R8: Whenever `out_de` is low, `out_a` and `out_b` are zero.
- R9: `out_de`, `out_hs` and `out_vs` carry the `in_de`, `in_hs` and `in_vs` values of the cycle that completes the pixel (the only cycle in modes 0, 2 and 3, the second beat in mode 1), so they appear in the same cycle as that pixel's data.
- R10: In mode 1, if `in_de` falls after an odd number of beats, the unpaired beat produces no pixel with `out_de` high. `odd_err` pulses for one cycle, together with an `out_en` cycle that has `out_de` low, and the next line starts correctly aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Link mode request, latched during blanking |
| in_de | input | 1 | Input display enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_a | input | 8 | Input link A beat |
| in_b | input | 8 | Input link B beat |
| out_en | output | 1 | Pixel-rate enable |
| out_de | output | 1 | Aligned display enable |
| out_hs | output | 1 | Aligned horizontal sync |
| out_vs | output | 1 | Aligned vertical sync |
| out_a | output | 8 | Channel A word |
| out_b | output | 8 | Channel B word |
| odd_err | output | 1 | Unpaired-beat line-end pulse |

## Verification
The assertions assume that `mode_sel` settles during blanking at least one cycle before `in_de` rises. They also assume that `in_de` is low in the cycle just after reset is released. The stimulus changes `mode_sel` only in gaps of three or more blanking cycles, except for the deliberate change in the middle of a line for R2. It also keeps `in_de` low while reset is held. Data, sync values and line lengths are drawn at random, and lines of odd length are fed to the interleaved mode on purpose. Gap lengths are also random, so the blanking phase at each rising edge of `in_de` varies.

// File: rtl/pld_pkg.sv
package pld_pkg;

  typedef enum logic [1:0] {
    LM_DUAL12  = 2'd0,
    LM_ILV12   = 2'd1,
    LM_DUAL8   = 2'd2,
    LM_SINGLE8 = 2'd3
  } link_mode_e;

  function automatic logic is_paired(input link_mode_e m);
    return (m == LM_ILV12);
  endfunction

endpackage

// File: rtl/pld_mode_latch.sv
module pld_mode_latch
  import pld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_de,
  input  logic [1:0] mode_sel,
  output link_mode_e mode_q
);

  // the mode is loaded only during blanking so a line is never converted two ways
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= LM_DUAL12;
    end else if (!in_de) begin
      mode_q <= link_mode_e'(mode_sel);
    end
  end

  // R2: an active cycle never lets the latched mode move
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_de) |-> $stable(mode_q));

endmodule

// File: rtl/pld_phase_track.sv
module pld_phase_track
  import pld_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  link_mode_e mode_q,
  input  logic       in_de,
  output logic       pix_done,
  output logic       hi_beat,
  output logic       odd_end
);

  logic de_q;
  logic ph;
  logic paired;
  logic de_rise;
  logic second;

  assign paired   = is_paired(mode_q);
  assign de_rise  = in_de & ~de_q;
  // a rising display enable always opens a pair (R5)
  assign second   = paired & ph & ~de_rise;
  assign pix_done = ~paired | second;
  assign hi_beat  = paired & ~second;
  // a line that closed on a first beat leaves ph set in the first blank cycle
  assign odd_end  = paired & ~in_de & de_q & ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q <= 1'b0;
      ph   <= 1'b0;
    end else begin
      de_q <= in_de;
      if (!paired)      ph <= 1'b0;
      else if (de_rise) ph <= 1'b1;
      else if (odd_end) ph <= 1'b0;
      else              ph <= ~ph;
    end
  end

  // R5: the beat at the rising enable is always taken as the high beat
  p_rise_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (paired && in_de && !de_q) |-> (hi_beat && !pix_done));

  // R10: the pair phase is cleared after an unpaired line end
  p_odd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    odd_end |=> !ph);

endmodule

// File: rtl/pld_out_stage.sv
module pld_out_stage
  import pld_pkg::*;
#(
  parameter int CH_W = 8,
  parameter int LO_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  link_mode_e      mode_q,
  input  logic            pix_done,
  input  logic            hi_beat,
  input  logic            odd_end,
  input  logic            in_de,
  input  logic            in_hs,
  input  logic            in_vs,
  input  logic [CH_W-1:0] in_a,
  input  logic [CH_W-1:0] in_b,
  output logic            out_en,
  output logic            out_de,
  output logic            out_hs,
  output logic            out_vs,
  output logic [CH_W-1:0] out_a,
  output logic [CH_W-1:0] out_b,
  output logic            odd_err
);

  localparam int PAD_W = CH_W - LO_W;

  logic [CH_W-1:0] hi_q;

  function automatic logic [CH_W-1:0] low_part(input logic [CH_W-1:0] w);
    return {{PAD_W{1'b0}}, w[LO_W-1:0]};
  endfunction

  function automatic logic [CH_W-1:0] chan_a(input link_mode_e m,
                                             input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] held);
    return (m == LM_ILV12) ? held : a;
  endfunction

  function automatic logic [CH_W-1:0] chan_b(input link_mode_e m,
                                             input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] b);
    case (m)
      LM_DUAL12: return low_part(b);
      LM_ILV12:  return low_part(a);
      LM_DUAL8:  return b;
      default:   return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      out_en  <= 1'b0;
      out_de  <= 1'b0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_a   <= '0;
      out_b   <= '0;
      odd_err <= 1'b0;
    end else begin
      out_en  <= pix_done;
      odd_err <= odd_end;
      if (hi_beat) hi_q <= in_a;
      if (pix_done) begin
        out_de <= in_de;
        out_hs <= in_hs;
        out_vs <= in_vs;
        out_a  <= in_de ? chan_a(mode_q, in_a, hi_q) : '0;
        out_b  <= in_de ? chan_b(mode_q, in_a, in_b) : '0;
      end
    end
  end

  // R8: blanking words are zero
  p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_a == '0 && out_b == '0));

  // R3 and R4: a 12-bit low part never reaches the upper bits of channel B
  p_low_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_de && (mode_q == LM_DUAL12 || mode_q == LM_ILV12))
      |-> (out_b[CH_W-1:LO_W] == '0));

  // R4: pixel enables are spaced by two cycles inside an interleaved line
  p_ilv_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LM_ILV12 && out_en && out_de) |=> !out_en);

  // R7: channel B is idle in single 8-bit mode
  p_single_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LM_SINGLE8 && out_de) |-> (out_b == '0));

  // R10: the error pulse comes with a dropped, non-displayed pixel slot
  p_err_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |-> (out_en && !out_de));

endmodule

// File: rtl/pixel_link_demux.sv
module pixel_link_demux
  import pld_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              in_de,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_en,
  output logic              out_de,
  output logic              out_hs,
  output logic              out_vs,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic              odd_err
);

  link_mode_e mode_q;
  logic       pix_done;
  logic       hi_beat;
  logic       odd_end;

  pld_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_de    (in_de),
    .mode_sel (mode_sel),
    .mode_q   (mode_q)
  );

  pld_phase_track u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .in_de    (in_de),
    .pix_done (pix_done),
    .hi_beat  (hi_beat),
    .odd_end  (odd_end)
  );

  pld_out_stage #(
    .CH_W (DATA_W),
    .LO_W (LO_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .pix_done (pix_done),
    .hi_beat  (hi_beat),
    .odd_end  (odd_end),
    .in_de    (in_de),
    .in_hs    (in_hs),
    .in_vs    (in_vs),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_en   (out_en),
    .out_de   (out_de),
    .out_hs   (out_hs),
    .out_vs   (out_vs),
    .out_a    (out_a),
    .out_b    (out_b),
    .odd_err  (odd_err)
  );

endmodule

// File: tb/test_pixel_link_demux.sv
`timescale 1ns/1ps
module test_pixel_link_demux;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       in_de = 1'b0;
  logic       in_hs = 1'b0;
  logic       in_vs = 1'b0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       out_en, out_de, out_hs, out_vs, odd_err;
  logic [7:0] out_a, out_b;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int blank_bad = 0;
  int err_cnt = 0;
  bit done = 0;

  logic [7:0] cap_a[$];
  logic [7:0] cap_b[$];
  logic       cap_hs[$];
  logic       cap_vs[$];
  int         cap_cyc[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pixel_link_demux i_pixel_link_demux (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_de(in_de),
    .in_hs(in_hs), .in_vs(in_vs), .in_a(in_a), .in_b(in_b),
    .out_en(out_en), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
    .out_a(out_a), .out_b(out_b), .odd_err(odd_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_en && out_de) begin
        cap_a.push_back(out_a);
        cap_b.push_back(out_b);
        cap_hs.push_back(out_hs);
        cap_vs.push_back(out_vs);
        cap_cyc.push_back(cyc);
      end
      if (!out_de && (out_a != 0 || out_b != 0)) blank_bad++;
      if (odd_err) err_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_b(input int m, input logic [7:0] a2,
                                       input logic [7:0] b);
    if (m == 0) return b & 8'h0f;
    if (m == 1) return a2 & 8'h0f;
    if (m == 2) return b;
    return 8'h00;
  endfunction

  task automatic blank_beat();
    @(negedge clk);
    in_de = 1'b0;
    in_a  = 8'($urandom);
    in_b  = 8'($urandom);
    in_hs = 1'($urandom);
    in_vs = 1'($urandom);
  endtask

  task automatic run_line(input int m, input int nb, input int gap,
                          input bit flip, input string req);
    logic [7:0] ba[$];
    logic [7:0] bb[$];
    logic       bh[$];
    logic       bv[$];
    logic [7:0] ea[$];
    logic [7:0] eb[$];
    logic       eh[$];
    logic       ev[$];
    int c0 = 0;
    int lat;
    int step;
    int n;
    mode_sel = 2'(m);
    cap_a.delete(); cap_b.delete(); cap_hs.delete(); cap_vs.delete();
    cap_cyc.delete();
    err_cnt = 0;
    for (int g = 0; g < gap; g++) blank_beat();
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_de = 1'b1;
      in_a  = 8'($urandom);
      in_b  = 8'($urandom);
      in_hs = 1'($urandom);
      in_vs = 1'($urandom);
      ba.push_back(in_a); bb.push_back(in_b);
      bh.push_back(in_hs); bv.push_back(in_vs);
      if (i == 0) c0 = cyc;
      if (flip && i == nb / 2) mode_sel = 2'(m ^ 1);
    end
    @(negedge clk);
    mode_sel = 2'(m);
    in_de = 1'b0;
    for (int g = 0; g < 5; g++) blank_beat();
    if (m == 1) begin
      for (int k = 0; k < nb / 2; k++) begin
        ea.push_back(ba[2*k]);
        eb.push_back(exp_b(1, ba[2*k+1], 8'h00));
        eh.push_back(bh[2*k+1]);
        ev.push_back(bv[2*k+1]);
      end
      lat = 2; step = 2;
    end else begin
      for (int k = 0; k < nb; k++) begin
        ea.push_back(ba[k]);
        eb.push_back(exp_b(m, 8'h00, bb[k]));
        eh.push_back(bh[k]);
        ev.push_back(bv[k]);
      end
      lat = 1; step = 1;
    end
    chk(cap_a.size() == ea.size(), req, "pixel count", cap_a.size(), ea.size());
    n = (cap_a.size() < ea.size()) ? cap_a.size() : ea.size();
    for (int k = 0; k < n; k++) begin
      chk(cap_a[k] == ea[k], req, "channel A", cap_a[k], ea[k]);
      chk(cap_b[k] == eb[k], req, "channel B", cap_b[k], eb[k]);
      // R9: syncs follow the completing beat
      chk(cap_hs[k] == eh[k] && cap_vs[k] == ev[k], "R9", "syncs",
          {cap_hs[k], cap_vs[k]}, {eh[k], ev[k]});
      chk(cap_cyc[k] == c0 + lat + step * k, req, "pixel timing",
          cap_cyc[k], c0 + lat + step * k);
    end
    // R10: one error pulse only for an unpaired interleaved line
    chk(err_cnt == ((m == 1 && (nb % 2) == 1) ? 1 : 0), "R10", "error pulses",
        err_cnt, (m == 1 && (nb % 2) == 1) ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_en == 0 && out_de == 0 && out_hs == 0 && out_vs == 0 &&
        out_a == 0 && out_b == 0 && odd_err == 0, "R1", "reset outputs",
        {out_en, out_de, out_hs, out_vs, odd_err}, 0);
    chk(out_a == 0 && out_b == 0, "R1", "reset words", {out_a, out_b}, 0);
    rst_n = 1'b1;
    // R3: dual 12-bit passthrough
    run_line(0, 9, 4, 1'b0, "R3");
    run_line(0, 1, 3, 1'b0, "R3");
    // R4: interleaved pairs
    run_line(1, 8, 4, 1'b0, "R4");
    run_line(1, 2, 3, 1'b0, "R4");
    // R5: different blanking phase before the rising enable
    run_line(1, 6, 3, 1'b0, "R5");
    run_line(1, 6, 4, 1'b0, "R5");
    run_line(1, 4, 7, 1'b0, "R5");
    // R6: dual 8-bit
    run_line(2, 10, 4, 1'b0, "R6");
    // R7: single 8-bit
    run_line(3, 10, 4, 1'b0, "R7");
    // R2: mode request changed mid line is ignored
    run_line(0, 10, 4, 1'b1, "R2");
    run_line(2, 10, 4, 1'b1, "R2");
    // R10: odd interleaved line, then a clean one
    run_line(1, 7, 4, 1'b0, "R10");
    run_line(1, 1, 3, 1'b0, "R10");
    run_line(1, 6, 3, 1'b0, "R10");
    // mixed random lines
    for (int t = 0; t < 40; t++) begin
      int m;
      m = int'($urandom % 4);
      run_line(m, 1 + int'($urandom % 16), 3 + int'($urandom % 5), 1'b0,
               (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R6" : "R7");
    end
    // R8: blanking words zero throughout
    chk(blank_bad == 0, "R8", "nonzero blank words", blank_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule